// File: doc/BRIEF.md
# Grouped Polled Interrupt Controller

This block collects interrupt events for a small 8-bit processor and presents them as two level-sensitive lines, one non-maskable (NMI) and one maskable (IRQ). Sources fall into one NMI group and four IRQ groups. Each group has a request register and an enable register of its own. A request is latched whenever its event occurs, whether or not it is enabled. Software clears a request by writing a one to its bit. A read-only polling register gives one summary bit per group, so a service routine can find the active group first and then read that group's request register.

Three pins are asynchronous and edge triggered: two external interrupt pins and the vertical-sync input. Each pin passes through a synchroniser. A trigger-select register chooses rising or falling edge detection for each pin. All other sources are single-cycle pulses from on-chip logic and are latched on the clock edge where they are high.

Register map (byte offsets): 0x10 NMI enable (bits 1:0), 0x11 to 0x14 IRQ group 0 to 3 enable, 0x15 polling summary, 0x16 NMI requests, 0x1C / 0x1D / 0x1E IRQ group 0 / 1 / 2 requests, 0x1B IRQ group 3 requests, 0x1F trigger select.

Top module: `gpic_top`

## Requirements
- R1: After reset, every enable register reads 0x00, every request register and the polling register read 0x00, trigger select reads 0xFF, and both `nmi_o` and `irq_o` are low.
- R2: The enable registers read back the value last written. The NMI enable keeps only bits 1:0, and its upper bits read as 0.
- R3: An event pulse that is high at a rising clock edge sets its request bit at that edge, whatever the state of the matching enable bit. Source bit n of IRQ group g is `irq_evt_i[8*g+n]`. NMI bit 1 is `mute_evt_i`.
- R4: Writing a request register clears each bit that is written as 1 and leaves each bit that is written as 0 unchanged.
- R5: If an event arrives on the same clock edge as a write that clears its bit, the bit ends up set.
- R6: Polling register bits 3:0 are set while any request of IRQ group 3:0 is pending. Bit 4 is set while any NMI request is pending. Bits 7:5 read 0. A summary bit drops only once every request in its group has been cleared. Writes to the polling register are ignored.
- R7: `irq_o` is high while any IRQ-group request is both pending and enabled. `nmi_o` is high while any NMI request is both pending and enabled.
- R8: Trigger-select bit 0 applies to `ext0_i` (NMI bit 0), bit 1 to `ext1_i` (IRQ group 1 bit 0) and bit 2 to `vsync_i` (IRQ group 2 bit 0). A bit of 1 selects a rising edge and 0 selects a falling edge. The request bit can be read as set after the third rising clock edge that follows the pin change. An edge of the opposite sense sets nothing.
- R9: Unmapped offsets read 0x00. IRQ group 0 implements only bits 4:0, so its bits 7:5 never set. The event inputs at positions 8 and 16 are unused, because those request bits come from the pins.
- R10: A pending, enabled request keeps its output asserted on every cycle until software clears the request or the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register offset |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| ext0_i | input | 1 | External interrupt pin, NMI group |
| ext1_i | input | 1 | External interrupt pin, IRQ group 1 |
| vsync_i | input | 1 | Vertical-sync pin, IRQ group 2 |
| mute_evt_i | input | 1 | Mute event pulse, NMI group |
| irq_evt_i | input | 32 | Peripheral event pulses, 8 per IRQ group |
| nmi_o | output | 1 | Non-maskable interrupt request, level |
| irq_o | output | 1 | Maskable interrupt request, level |

## Verification
The assertions assume the following about the inputs:
- Requests and enables change only through the register bus or through events.
- Trigger select is not rewritten while a pin edge is still passing through its synchroniser. The single-pulse check on the edge detector depends on this.

The stimulus keeps within these assumptions. It drives pins and event pulses on the falling clock edge and leaves a quiet interval of at least four cycles after each pin change. It changes trigger select only while every pin is steady. Bus addresses and write data are likewise set up half a cycle before the edge that samples them.

// File: rtl/gpic_pkg.sv
package gpic_pkg;
  localparam int GRP_W      = 8;
  localparam int NUM_IRQ    = 4;
  localparam int NMI_W      = 2;
  localparam int NUM_PIN    = 3;

  localparam logic [7:0] A_EN_NMI = 8'h10;
  localparam logic [7:0] A_EN_IRQ = 8'h11;  // groups at +0..+3
  localparam logic [7:0] A_POLL   = 8'h15;
  localparam logic [7:0] A_REQ_NMI = 8'h16;
  localparam logic [7:0] A_TRIG   = 8'h1F;

  function automatic logic [7:0] irq_req_addr(input int g);
    case (g)
      0:       return 8'h1C;
      1:       return 8'h1D;
      2:       return 8'h1E;
      default: return 8'h1B;
    endcase
  endfunction

  function automatic logic [7:0] irq_valid(input int g);
    return (g == 0) ? 8'h1F : 8'hFF;
  endfunction

  // request bit 0 of group g driven by a pin instead of irq_evt_i
  function automatic logic [7:0] irq_pin_mask(input int g);
    return (g == 1 || g == 2) ? 8'h01 : 8'h00;
  endfunction
endpackage

// File: rtl/gpic_edge_det.sv
module gpic_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic rise_sel_i,
  output logic pulse_o
);
  logic s1_q, s2_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= pin_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign pulse_o = rise_sel_i ? (s2_q & ~prev_q) : (~s2_q & prev_q);

  // R8: one pin transition yields one detect cycle
  a_r8_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> (!pulse_o || !$stable(rise_sel_i)));
endmodule

// File: rtl/gpic_req_group.sv
module gpic_req_group #(
  parameter int         W     = 8,
  parameter logic [W-1:0] VALID = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         req_we_i,
  input  logic         en_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] req_o,
  output logic [W-1:0] en_o,
  output logic         pend_o,
  output logic         int_o
);
  logic [W-1:0] req_q, en_q, set_m, clr_m;

  assign set_m = set_i & VALID;
  assign clr_m = req_we_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= '0;
      en_q  <= '0;
    end else begin
      if (en_we_i) en_q <= wdata_i;
      req_q <= (req_q & ~clr_m) | set_m;  // new event beats clear
    end
  end

  assign req_o  = req_q;
  assign en_o   = en_q;
  assign pend_o = |req_q;
  assign int_o  = |(req_q & en_q);

  // R4: bits written as 1 are clear unless an event hit them
  a_r4_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_we_i |=> (req_q & $past(wdata_i) & ~$past(set_i & VALID)) == '0);
  // R5: an event always lands
  a_r5_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(set_i & VALID)) |=> ((req_q & $past(set_i & VALID)) == $past(set_i & VALID)));
  // R3: pending bits never drop without a write
  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_we_i |=> ((req_q & $past(req_q)) == $past(req_q)));
  // R9: unimplemented bits stay clear
  a_r9_unused_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q & ~VALID) == '0);
endmodule

// File: rtl/gpic_top.sv
module gpic_top
  import gpic_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  addr_i,
  input  logic        we_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  input  logic        ext0_i,
  input  logic        ext1_i,
  input  logic        vsync_i,
  input  logic        mute_evt_i,
  input  logic [31:0] irq_evt_i,
  output logic        nmi_o,
  output logic        irq_o
);
  localparam int EVT_W = NUM_IRQ * GRP_W;

  logic [7:0]          trig_q;
  logic [NUM_PIN-1:0]  pins, pin_pulse;
  logic [NMI_W-1:0]    nmi_set, nmi_req, nmi_en;
  logic                nmi_pend, nmi_int;
  logic [GRP_W-1:0]    irq_set [NUM_IRQ];
  logic [GRP_W-1:0]    irq_req [NUM_IRQ];
  logic [GRP_W-1:0]    irq_en  [NUM_IRQ];
  logic [NUM_IRQ-1:0]  irq_pend, irq_int;
  logic [7:0]          poll;

  // trigger select: 1 = rising
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      trig_q <= 8'hFF;
    else if (we_i && addr_i == A_TRIG) trig_q <= wdata_i;
  end

  assign pins = {vsync_i, ext1_i, ext0_i};

  for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
    gpic_edge_det u_edge (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pin_i      (pins[p]),
      .rise_sel_i (trig_q[p]),
      .pulse_o    (pin_pulse[p])
    );
  end

  assign nmi_set = {mute_evt_i, pin_pulse[0]};

  gpic_req_group #(.W(NMI_W), .VALID('1)) u_nmi (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (nmi_set),
    .req_we_i (we_i && addr_i == A_REQ_NMI),
    .en_we_i  (we_i && addr_i == A_EN_NMI),
    .wdata_i  (wdata_i[NMI_W-1:0]),
    .req_o    (nmi_req),
    .en_o     (nmi_en),
    .pend_o   (nmi_pend),
    .int_o    (nmi_int)
  );

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_irq
    localparam logic [7:0] PMASK = irq_pin_mask(g);
    logic pin_bit;
    if (g == 1)      begin : g_p1 assign pin_bit = pin_pulse[1]; end
    else if (g == 2) begin : g_p2 assign pin_bit = pin_pulse[2]; end
    else             begin : g_p0 assign pin_bit = 1'b0;         end

    assign irq_set[g] = (irq_evt_i[g*GRP_W +: GRP_W] & ~PMASK)
                      | (PMASK & {GRP_W{pin_bit}});

    gpic_req_group #(.W(GRP_W), .VALID(irq_valid(g))) u_grp (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .set_i    (irq_set[g]),
      .req_we_i (we_i && addr_i == irq_req_addr(g)),
      .en_we_i  (we_i && addr_i == A_EN_IRQ + 8'(g)),
      .wdata_i  (wdata_i),
      .req_o    (irq_req[g]),
      .en_o     (irq_en[g]),
      .pend_o   (irq_pend[g]),
      .int_o    (irq_int[g])
    );

    // R6: summary falls only after a bus write
    a_r6_poll_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(irq_pend[g]) |-> $past(we_i));
  end

  assign poll  = {3'b000, nmi_pend, irq_pend};
  assign irq_o = |irq_int;
  assign nmi_o = nmi_int;

  always_comb begin
    rdata_o = 8'h00;
    case (addr_i)
      A_EN_NMI:           rdata_o = {{(8-NMI_W){1'b0}}, nmi_en};
      A_EN_IRQ:           rdata_o = irq_en[0];
      A_EN_IRQ + 8'd1:    rdata_o = irq_en[1];
      A_EN_IRQ + 8'd2:    rdata_o = irq_en[2];
      A_EN_IRQ + 8'd3:    rdata_o = irq_en[3];
      A_POLL:             rdata_o = poll;
      A_REQ_NMI:          rdata_o = {{(8-NMI_W){1'b0}}, nmi_req};
      8'h1B:              rdata_o = irq_req[3];
      8'h1C:              rdata_o = irq_req[0];
      8'h1D:              rdata_o = irq_req[1];
      8'h1E:              rdata_o = irq_req[2];
      A_TRIG:             rdata_o = trig_q;
      default:            rdata_o = 8'h00;
    endcase
  end

  // R7: an output needs a pending request behind it
  a_r7_irq_needs_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|irq_pend));
  a_r7_nmi_needs_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_o |-> nmi_pend);
  // R10: asserted outputs hold without a bus write
  a_r10_irq_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !we_i) |=> irq_o);
  a_r10_nmi_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_o && !we_i) |=> nmi_o);
  // R9: width parameter matches the event bus
  initial a_r9_evt_width: assert (EVT_W == 32);
endmodule

// File: tb/sim_gpic_top.sv
`timescale 1ns/1ps
module sim_gpic_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic        we = 1'b0;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata;
  logic        ext0 = 1'b0, ext1 = 1'b0, vsync = 1'b0, mute = 1'b0;
  logic [31:0] evt = '0;
  logic        nmi, irq;
  int          errors = 0;
  int          checks = 0;

  always #2.5 clk = ~clk;

  gpic_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .ext0_i(ext0), .ext1_i(ext1), .vsync_i(vsync),
    .mute_evt_i(mute), .irq_evt_i(evt), .nmi_o(nmi), .irq_o(irq)
  );

  // {we, addr, wdata, expected read}
  localparam int NV = 19;
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 8'h10, 8'hFF, 8'h00}, {1'b0, 8'h10, 8'h00, 8'h03},
    {1'b1, 8'h11, 8'hA5, 8'h00}, {1'b0, 8'h11, 8'h00, 8'hA5},
    {1'b1, 8'h14, 8'h3C, 8'h00}, {1'b0, 8'h14, 8'h00, 8'h3C},
    {1'b1, 8'h15, 8'hFF, 8'h00}, {1'b0, 8'h15, 8'h00, 8'h00},
    {1'b0, 8'h05, 8'h00, 8'h00}, {1'b0, 8'h1A, 8'h00, 8'h00},
    {1'b0, 8'hFF, 8'h00, 8'h00},
    {1'b1, 8'h1F, 8'hF0, 8'h00}, {1'b0, 8'h1F, 8'h00, 8'hF0},
    {1'b1, 8'h1F, 8'hFF, 8'h00}, {1'b0, 8'h1F, 8'h00, 8'hFF},
    {1'b1, 8'h10, 8'h00, 8'h00}, {1'b1, 8'h11, 8'h00, 8'h00},
    {1'b1, 8'h14, 8'h00, 8'h00}, {1'b0, 8'h10, 8'h00, 8'h00}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic chk_rd(input string tag, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk); we = 1'b0; addr = a;
    #1 check(tag, rdata, exp);
  endtask

  task automatic chk_out(input string tag, input logic act, input logic exp);
    @(negedge clk); #1 check(tag, {7'b0, act}, {7'b0, exp});
  endtask

  task automatic pulse(input int idx);
    @(negedge clk); evt[idx] = 1'b1;
    @(negedge clk); evt[idx] = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 8'h10; a <= 8'h1E; a++) chk_rd("R1 reset reg", 8'(a), 8'h00);
    chk_rd("R1 reset trigger", 8'h1F, 8'hFF);
    chk_out("R1 reset irq_o", irq, 1'b0);
    chk_out("R1 reset nmi_o", nmi, 1'b0);

    // R2 R6 R9 table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][24]) wr(VEC[i][23:16], VEC[i][15:8]);
      else chk_rd($sformatf("R2/R6/R9 table[%0d]", i), VEC[i][23:16], VEC[i][7:0]);
    end

    // R3 latch while disabled
    pulse(2);
    chk_rd("R3 group0 latch", 8'h1C, 8'h04);
    chk_out("R3 disabled irq_o", irq, 1'b0);
    chk_rd("R6 poll group0", 8'h15, 8'h01);
    pulse(6);
    chk_rd("R9 group0 bit6 unused", 8'h1C, 8'h04);

    // R7 enable, R10 level
    wr(8'h11, 8'h04);
    chk_out("R7 irq_o enabled", irq, 1'b1);
    chk_out("R7 nmi_o idle", nmi, 1'b0);
    repeat (20) @(negedge clk);
    chk_out("R10 irq_o held", irq, 1'b1);

    // R4 write one to clear
    wr(8'h1C, 8'h00);
    chk_rd("R4 zero write keeps", 8'h1C, 8'h04);
    wr(8'h1C, 8'h04);
    chk_rd("R4 one write clears", 8'h1C, 8'h00);
    chk_rd("R6 poll cleared", 8'h15, 8'h00);
    chk_out("R7 irq_o after clear", irq, 1'b0);

    // R6 summary drops after last member only
    pulse(11); pulse(13);
    chk_rd("R3 group1 two bits", 8'h1D, 8'h28);
    wr(8'h1D, 8'h08);
    chk_rd("R6 poll with one left", 8'h15, 8'h02);
    wr(8'h15, 8'h00);
    chk_rd("R6 poll write ignored", 8'h15, 8'h02);
    wr(8'h1D, 8'h20);
    chk_rd("R6 poll all clear", 8'h15, 8'h00);

    // R5 event beats clear
    pulse(13);
    @(negedge clk); addr = 8'h1D; wdata = 8'h28; we = 1'b1; evt[11] = 1'b1;
    @(negedge clk); we = 1'b0; evt[11] = 1'b0;
    chk_rd("R5 set wins", 8'h1D, 8'h08);
    wr(8'h1D, 8'h08);

    // R8 ext1 rising then falling
    @(negedge clk); ext1 = 1'b1; settle();
    chk_rd("R8 ext1 rising", 8'h1D, 8'h01);
    chk_out("R7 group1 disabled", irq, 1'b0);
    wr(8'h1D, 8'h01);
    wr(8'h1F, 8'hFD);
    @(negedge clk); ext1 = 1'b0; settle();
    chk_rd("R8 ext1 falling", 8'h1D, 8'h01);
    wr(8'h1D, 8'h01);
    @(negedge clk); ext1 = 1'b1; settle();
    chk_rd("R8 ext1 rising ignored", 8'h1D, 8'h00);
    wr(8'h1F, 8'hFF);
    settle();
    chk_rd("R8 select change no event", 8'h1D, 8'h00);

    // R8 vsync
    @(negedge clk); vsync = 1'b1; settle();
    chk_rd("R8 vsync rising", 8'h1E, 8'h01);
    wr(8'h13, 8'h01);
    chk_out("R7 irq_o group2", irq, 1'b1);
    wr(8'h1E, 8'h01);
    chk_out("R7 irq_o group2 cleared", irq, 1'b0);
    @(negedge clk); vsync = 1'b0; settle();
    chk_rd("R8 vsync falling ignored", 8'h1E, 8'h00);

    // NMI group
    @(negedge clk); ext0 = 1'b1; settle();
    chk_rd("R8 ext0 rising", 8'h16, 8'h01);
    chk_rd("R6 poll nmi", 8'h15, 8'h10);
    chk_out("R3 nmi disabled", nmi, 1'b0);
    wr(8'h10, 8'h01);
    chk_out("R7 nmi_o enabled", nmi, 1'b1);
    chk_out("R7 irq_o unaffected", irq, 1'b0);
    @(negedge clk); mute = 1'b1;
    @(negedge clk); mute = 1'b0;
    chk_rd("R3 mute latch", 8'h16, 8'h03);
    wr(8'h16, 8'h01);
    chk_out("R7 nmi_o mute masked", nmi, 1'b0);
    chk_rd("R6 poll nmi partial", 8'h15, 8'h10);
    wr(8'h16, 8'h02);
    chk_rd("R6 poll nmi clear", 8'h15, 8'h00);

    // group 3
    pulse(31);
    chk_rd("R3 group3 latch", 8'h1B, 8'h80);
    chk_rd("R6 poll group3", 8'h15, 8'h08);
    wr(8'h14, 8'h80);
    chk_out("R7 irq_o group3", irq, 1'b1);
    wr(8'h1B, 8'h80);
    chk_out("R7 irq_o group3 cleared", irq, 1'b0);

    // R1 reset mid-run
    pulse(24);
    wr(8'h1F, 8'h00);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk_rd("R1 rerset request", 8'h1B, 8'h00);
    chk_rd("R1 rerset enable", 8'h14, 8'h00);
    chk_rd("R1 rerset trigger", 8'h1F, 8'hFF);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule